// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that gives an external controller read and write access to a bank of 8-bit configuration registers. The controller pulls the active-low select line low and toggles a serial clock. The block samples incoming bits on rising clock edges and launches outgoing bits after falling edges. Every transfer opens with one instruction byte that names a direction and a starting register. Any number of data bytes follow it, and the internal address moves by one after each data byte. All stored registers are also presented at once on a flat parallel output, so the rest of the chip can use them directly.

The select, clock and data inputs are asynchronous to the system clock. They are brought through a synchronizer and edge-detected, so the serial clock must run several times slower than the system clock. A control bit in register 0x00 chooses the bit order. The same bit also chooses which way the address moves during a multibyte transfer. It is taken as the transfer begins, so the whole frame uses one order. The data line is split into an input, an output and an output enable, and a pad-level tristate combines them.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, except register 0x1F, which holds the VERSION parameter (default 0x5A). The output enable is low.
- R2: The first byte of a transfer is the instruction. In its logical value, bit 7 = 1 selects a read and bit 7 = 0 selects a write, and bits 6:0 give the starting address.
- R3: While register 0x00 bit 0 is 0, bits travel most significant first, both in the instruction and in the data. The address decrements after each data byte, wrapping modulo 128.
- R4: While register 0x00 bit 0 is 1, bits travel least significant first, both in the instruction and in the data. The address increments after each data byte, wrapping modulo 128.
- R5: The bit order is sampled only while select is high. Writing register 0x00 during a transfer changes neither the order nor the address direction of the rest of that transfer.
- R6: Writes are masked per register. Register 0x00 stores only bit 0. Registers 0x04 and 0x07 store bits 7 and 5:0, and their bit 6 reads 0. Every other writable register stores all 8 bits.
- R7: Register 0x1F is read-only. It always returns VERSION, and writes to it are ignored.
- R8: Addresses from 32 to 127 read as 0x00, and writes to them change no register.
- R9: Raising select at any point ends the transfer and discards a partly shifted byte. The next transfer starts again with an instruction byte.
- R10: The output enable is high only while select is low, in the data phase of a read. The output bit changes only after falling serial clock edges and is stable for the following rising edge.
- R11: regs_o carries register i in bits 8*i+7 : 8*i. It changes only when a write data byte completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low transfer select |
| sclk | input | 1 | Serial clock from the controller |
| sdio_i | input | 1 | Serial data from the pad |
| sdio_o | output | 1 | Serial read data to the pad |
| sdio_oe | output | 1 | Pad drive enable for sdio_o |
| regs_o | output | NUM_REGS*8 | Flat parallel image of the register bank |

## Verification
The hardest case to reach from the ports is a transfer that rewrites the bit-order control while it is running. A mode change that takes effect too early would redirect the remaining bytes of that same frame. The stimulus makes this case by starting a most-significant-first write at 0x01. That write runs down through 0x00, setting the order bit, and then on to the out-of-range address 0x7F. If the mode leaked into the frame, the third byte would land, bit-reversed, on 0x01, and the per-clock comparison of the register image would expose it. Aborts are reached by raising select after a whole instruction and part of a data byte, and also in the middle of an instruction. The address wrap is reached by a descending read that starts at 0x01.

// File: rtl/cfgport_pkg.sv
`timescale 1ns/1ps
package cfgport_pkg;
  localparam int ADDR_W   = 7;
  localparam int CTRL_IDX = 0;
  localparam int GAIN_A   = 4;
  localparam int GAIN_B   = 7;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_t;

  // next shift-register value for one sampled bit
  function automatic logic [7:0] shift_in(input logic [7:0] sr, input logic d,
                                          input logic lsb_first);
    return lsb_first ? {d, sr[7:1]} : {sr[6:0], d};
  endfunction

  // byte address after a completed data byte
  function automatic addr_t step_addr(input addr_t a, input logic lsb_first);
    return lsb_first ? addr_t'(a + 1'b1) : addr_t'(a - 1'b1);
  endfunction

  // bit launched as the n-th bit of a byte
  function automatic logic out_bit(input logic [7:0] b, input logic [2:0] n,
                                   input logic lsb_first);
    return lsb_first ? b[n] : b[3'd7 - n];
  endfunction

  // which bits of register idx a write may change
  function automatic logic [7:0] write_mask(input int idx, input int ro_idx);
    if (idx == ro_idx) return 8'h00;
    if (idx == CTRL_IDX) return 8'h01;
    if (idx == GAIN_A || idx == GAIN_B) return 8'hBF;
    return 8'hFF;
  endfunction
endpackage

// File: rtl/cfgport_sync.sv
`timescale 1ns/1ps
module cfgport_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgport_frame.sv
`timescale 1ns/1ps
module cfgport_frame import cfgport_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_act,
  input  logic       sclk_s,
  input  logic       sdi_s,
  input  logic       ctrl_lsb,
  input  logic [7:0] rd_data,
  output addr_t      acc_addr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sdo,
  output logic       sdo_en,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       in_data,
  output logic       rd_cycle,
  output logic       lsb_mode
);
  logic       sclk_q;
  phase_t     phase_q;
  logic       rw_q, mode_q, dout_q;
  addr_t      addr_q;
  logic [2:0] bcnt_q;
  logic [7:0] sr_q, tx_q;
  logic [7:0] sr_next, tx_src;
  logic       byte_end;

  assign rise_ev  = cs_act &  sclk_s & ~sclk_q;
  assign fall_ev  = cs_act & ~sclk_s &  sclk_q;
  assign sr_next  = shift_in(sr_q, sdi_s, mode_q);
  assign byte_end = rise_ev && (bcnt_q == 3'd7);
  assign in_data  = (phase_q == PH_DATA);
  assign wr_en    = byte_end && in_data && !rw_q;
  assign wr_data  = sr_next;
  assign acc_addr = addr_q;
  // a new read byte is fetched at the first falling edge of each byte slot
  assign tx_src   = (bcnt_q == 3'd0) ? rd_data : tx_q;
  assign sdo      = dout_q;
  assign sdo_en   = cs_act && in_data && rw_q;
  assign rd_cycle = rw_q;
  assign lsb_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INSTR;
      rw_q    <= 1'b0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      bcnt_q  <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      dout_q  <= 1'b0;
    end else if (!cs_act) begin
      phase_q <= PH_INSTR;
      bcnt_q  <= '0;
      mode_q  <= ctrl_lsb;
    end else begin
      if (rise_ev) begin
        sr_q   <= sr_next;
        bcnt_q <= bcnt_q + 3'd1;
        if (byte_end) begin
          if (phase_q == PH_INSTR) begin
            rw_q    <= sr_next[7];
            addr_q  <= sr_next[6:0];
            phase_q <= PH_DATA;
          end else begin
            addr_q <= step_addr(addr_q, mode_q);
          end
        end
      end
      if (fall_ev && in_data && rw_q) begin
        tx_q   <= tx_src;
        dout_q <= out_bit(tx_src, bcnt_q, mode_q);
      end
    end
  end
endmodule

// File: rtl/cfgport_regbank.sv
`timescale 1ns/1ps
module cfgport_regbank import cfgport_pkg::*; #(
  parameter int         NUM_REGS = 32,
  parameter logic [7:0] VERSION  = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  addr_t                 wr_addr,
  input  logic [7:0]            wr_data,
  input  addr_t                 rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic                  ctrl_lsb
);
  localparam int RO_IDX = NUM_REGS - 1;
  localparam int IDX_W  = $clog2(NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] MASK = write_mask(i, RO_IDX);
    logic [7:0] q;
    if (i == RO_IDX) begin : g_ro
      assign q = VERSION;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && wr_addr == addr_t'(i)) q <= (q & ~MASK) | (wr_data & MASK);
      end
    end
    assign regs_flat[i*8 +: 8] = q;
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_REGS) rd_data = regs_flat[int'(rd_addr[IDX_W-1:0])*8 +: 8];
  end

  assign ctrl_lsb = regs_flat[CTRL_IDX*8];
endmodule

// File: rtl/serial_cfg_port.sv
`timescale 1ns/1ps
module serial_cfg_port import cfgport_pkg::*; #(
  parameter int         NUM_REGS    = 32,
  parameter logic [7:0] VERSION     = 8'h5A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sclk,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic       cs_n_s, sclk_s, sdi_s, cs_act;
  logic       ctrl_lsb, wr_en;
  logic [7:0] wr_data, rd_data;
  addr_t      acc_addr;
  logic       rise_ev, fall_ev, in_data, rd_cycle, lsb_mode;

  cfgport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sclk, sdio_i}),
    .q({cs_n_s, sclk_s, sdi_s})
  );

  assign cs_act = ~cs_n_s;

  cfgport_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .ctrl_lsb(ctrl_lsb), .rd_data(rd_data), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_data(wr_data), .sdo(sdio_o), .sdo_en(sdio_oe),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .in_data(in_data),
    .rd_cycle(rd_cycle), .lsb_mode(lsb_mode)
  );

  cfgport_regbank #(.NUM_REGS(NUM_REGS), .VERSION(VERSION)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(acc_addr),
    .wr_data(wr_data), .rd_addr(acc_addr), .rd_data(rd_data),
    .regs_flat(regs_o), .ctrl_lsb(ctrl_lsb)
  );
endmodule

// File: rtl/cfgport_chk.sv
`timescale 1ns/1ps
module cfgport_chk #(
  parameter int NUM_REGS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_act,
  input logic                  rise_ev,
  input logic                  fall_ev,
  input logic                  in_data,
  input logic                  lsb_mode,
  input logic                  wr_en,
  input logic [6:0]            wr_addr,
  input logic                  sdio_o,
  input logic                  sdio_oe,
  input logic [NUM_REGS*8-1:0] regs_o
);
  // R10
  oe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(rise_ev));

  // R10
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdio_o));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !in_data);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |-> $stable(lsb_mode));

  // R11
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

  // R8
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= NUM_REGS) |=> $stable(regs_o));
endmodule

bind serial_cfg_port cfgport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise_ev(rise_ev),
  .fall_ev(fall_ev), .in_data(in_data), .lsb_mode(lsb_mode),
  .wr_en(wr_en), .wr_addr(acc_addr), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
  .regs_o(regs_o)
);

// File: tb/tb_serial_cfg_port.sv
`timescale 1ns/1ps
module tb_serial_cfg_port;
  localparam int         NR   = 32;
  localparam logic [7:0] VER  = 8'h5A;
  localparam int         HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  wire            sdio_o, sdio_oe;
  wire [NR*8-1:0] regs_o;

  always #2.5 clk = ~clk;

  serial_cfg_port #(.NUM_REGS(NR), .VERSION(VER)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .regs_o(regs_o)
  );

  int vec = 0, bad = 0, settle = 0;
  bit cmp_en = 0, moe = 0, done = 0;
  logic [7:0] mreg [NR];
  logic [7:0] wq [$];

  function automatic logic [7:0] keep_bits(int a);
    case (a)
      0:       return 8'b0000_0001;
      4, 7:    return 8'b1011_1111;
      NR - 1:  return 8'b0000_0000;
      default: return 8'b1111_1111;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(int a);
    return (a < NR) ? mreg[a] : 8'h00;
  endfunction

  function automatic void model_wr(int a, logic [7:0] d);
    if (a < NR) mreg[a] = (mreg[a] & ~keep_bits(a)) | (d & keep_bits(a));
  endfunction

  task automatic chk(string tag, string what, logic [7:0] got, logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // per-clock comparison against the model, skipped just after serial edges
  always @(negedge clk) begin
    settle++;
    if (cmp_en && !done && settle >= 4) begin
      for (int i = 0; i < NR; i++) begin
        vec++;
        if (regs_o[i*8 +: 8] !== mreg[i]) begin
          bad++;
          $display("FAIL R11 reg %0d: got %h expected %h", i, regs_o[i*8 +: 8], mreg[i]);
        end
      end
      vec++;
      if (sdio_oe !== moe) begin
        bad++;
        $display("FAIL R10 sdio_oe: got %b expected %b", sdio_oe, moe);
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // shifts a byte; returns with sclk still high after the last rising edge
  task automatic send_byte(input logic [7:0] b, input bit lsb, output logic [7:0] got);
    got = '0;
    for (int k = 0; k < 8; k++) begin
      int idx = lsb ? k : 7 - k;
      sdio_i = b[idx];
      wait_clk(HALF);
      got[idx] = sdio_o;
      sclk = 1'b1; settle = 0;
      if (k < 7) begin
        wait_clk(HALF);
        sclk = 1'b0; settle = 0;
      end
    end
  endtask

  task automatic drop_sclk();
    wait_clk(HALF);
    sclk = 1'b0; settle = 0;
  endtask

  task automatic end_frame();
    wait_clk(HALF);
    cs_n = 1'b1; settle = 0; moe = 0;
    wait_clk(2 * HALF);
  endtask

  task automatic xfer(input bit rd, input int a0, input int n, input string tag);
    bit lsb = mreg[0][0];
    int a = a0;
    logic [7:0] got;
    cs_n = 1'b0; settle = 0;
    wait_clk(HALF);
    send_byte({rd, 7'(a0)}, lsb, got);
    if (rd) moe = 1;
    drop_sclk();
    for (int j = 0; j < n; j++) begin
      send_byte(rd ? 8'h00 : wq[j], lsb, got);
      if (rd) chk(tag, $sformatf("read addr %02h", a), got, model_rd(a));
      else model_wr(a, wq[j]);
      a = lsb ? (a + 1) % 128 : (a + 127) % 128;
      drop_sclk();
    end
    end_frame();
  endtask

  // abort: optional full instruction, then nbits extra ones, then select high
  task automatic partial(input logic [7:0] instr, input bit full, input int nbits);
    bit lsb = mreg[0][0];
    logic [7:0] got;
    cs_n = 1'b0; settle = 0;
    wait_clk(HALF);
    if (full) begin
      send_byte(instr, lsb, got);
      if (instr[7]) moe = 1;
      drop_sclk();
    end
    for (int k = 0; k < nbits; k++) begin
      sdio_i = 1'b1;
      wait_clk(HALF);
      sclk = 1'b1; settle = 0;
      wait_clk(HALF);
      sclk = 1'b0; settle = 0;
    end
    end_frame();
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) mreg[i] = 8'h00;
    mreg[NR-1] = VER;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    // R1: reset image
    chk("R1", "reg00", regs_o[7:0], 8'h00);
    chk("R1", "reg1F", regs_o[(NR-1)*8 +: 8], VER);
    chk("R1", "sdio_oe", {7'b0, sdio_oe}, 8'h00);
    cmp_en = 1;

    // R2 R6: single write with bit 6 masked, read back
    wq = {8'hFF};                 xfer(0, 8'h04, 1, "R6");
    xfer(1, 8'h04, 1, "R2");
    // R3: descending multibyte write and read
    wq = {8'h12, 8'h34, 8'h56};   xfer(0, 8'h0A, 3, "R3");
    xfer(1, 8'h0A, 3, "R3");
    // R8: descending read wraps from 0x00 to 0x7F
    xfer(1, 8'h01, 3, "R8");
    // R7: read-only version register
    wq = {8'h00};                 xfer(0, 8'h1F, 1, "R7");
    xfer(1, 8'h1F, 1, "R7");
    // R8: out-of-range write ignored
    wq = {8'hEE};                 xfer(0, 8'h40, 1, "R8");
    xfer(1, 8'h40, 1, "R8");
    // R5: switch to LSB-first mid-frame; the frame must finish MSB-first
    wq = {8'hA5, 8'hFF, 8'h3C};   xfer(0, 8'h01, 3, "R5");
    chk("R5", "mode bit", regs_o[7:0], 8'h01);
    xfer(1, 8'h01, 1, "R5");
    // R4: ascending multibyte in LSB-first order
    wq = {8'h81, 8'h42, 8'h0F};   xfer(0, 8'h0B, 3, "R4");
    xfer(1, 8'h0B, 3, "R4");
    xfer(1, 8'h1E, 3, "R4");
    wq = {8'hFF};                 xfer(0, 8'h07, 1, "R6");
    xfer(1, 8'h07, 1, "R6");
    // R9: abort mid-data and mid-instruction, then a clean frame
    wq = {8'h77};                 xfer(0, 8'h05, 1, "R9");
    partial(8'h05, 1, 4);
    partial(8'h00, 0, 5);
    xfer(1, 8'h05, 1, "R9");
    partial(8'h85, 1, 3);
    chk("R10", "oe after read abort", {7'b0, sdio_oe}, 8'h00);
    // back to MSB-first, then a walking pattern
    wq = {8'h00};                 xfer(0, 8'h00, 1, "R3");
    for (int p = 0; p < 4; p++) begin
      wq = {8'h01 << p, 8'hF0 >> p};
      xfer(0, 8'h12 + p, 2, "R3");
      xfer(1, 8'h12 + p, 2, "R11");
    end
    chk("R10", "oe idle", {7'b0, sdio_oe}, 8'h00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule